// File: doc/BRIEF.md
# Packed Signed Halving Add/Subtract Unit

This block performs SIMD arithmetic on two 32-bit operands. Each lane holds a signed sum or difference that is shifted right by one place, so the lane result always fits its width and never overflows. There are two lane modes. The halfword mode has two 16-bit lanes, with straight pairings and exchanged pairings. An exchanged pairing combines the low half of one operand with the high half of the other, and it adds in one lane while it subtracts in the other. The byte mode has four 8-bit lanes.

The unit accepts a 32-bit instruction word and decodes the operation selector and the register indices from it. The source indices go out at once, combinationally, so that a register file can return the two operand values in the same cycle. A condition field in the word gates the write. One clock later, registered outputs present either a write request (enable, destination index and packed result) or an invalid-operation flag. There is no state machine: the block is a decoder and a datapath feeding one register stage.

Top module: `phalf_unit`

## Requirements
- R1: Selector 0 (halfword add): each 16-bit lane of the result is (signed Rn lane + signed Rm lane) >>> 1. The sum is formed at 17 bits, so the result is exact.
- R2: Selector 3 (halfword subtract): each 16-bit lane is (signed Rn lane − signed Rm lane) >>> 1, formed at 17 bits.
- R3: Selector 1 (exchanged, subtract low): the low lane is (Rn[15:0] − Rm[31:16]) >>> 1 and the high lane is (Rn[31:16] + Rm[15:0]) >>> 1.
- R4: Selector 2 (exchanged, add low): the low lane is (Rn[15:0] + Rm[31:16]) >>> 1 and the high lane is (Rn[31:16] − Rm[15:0]) >>> 1.
- R5: Selector 4 performs signed halving add on four 8-bit lanes. Selector 7 performs signed halving subtract on the same four lanes.
- R6: Lane 0 sits in the least significant bits. Each halved lane result is truncated to its lane width and cannot overflow. The extreme cases give these results: 0x8000+0x8000 gives 0x8000, 0x7FFF−0x8000 gives 0x7FFF, and byte 0x80+0x80 gives 0x80.
- R7: The instruction word fields are placed as follows:
  - The condition is bits 31:28.
  - The selector is bits 7:5.
  - The first source index (rn_idx) is bits 19:16.
  - The second source index (rm_idx) is bits 3:0.
  - The destination index (wr_addr) is bits 15:12.
  - The source indices appear combinationally.
- R8: A condition value of 0xE always writes. Any other condition value writes only when cond_pass is high. Otherwise wr_en stays low.
- R9: Selectors 5 and 6 are undefined. For these, invalid_op is raised one cycle later and wr_en stays low, whatever the condition.
- R10: The outputs are registered with a latency of one cycle. With instr_valid low, wr_en and invalid_op are low in the next cycle. Reset clears wr_en, invalid_op, wr_addr and wr_data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | The instruction word is present this cycle |
| instr_word | input | 32 | Instruction word |
| cond_pass | input | 1 | The external condition evaluation passed |
| rn_data | input | DATA_W | First operand value |
| rm_data | input | DATA_W | Second operand value |
| rn_idx | output | 4 | First source register index (combinational) |
| rm_idx | output | 4 | Second source register index (combinational) |
| wr_en | output | 1 | Destination write enable (registered) |
| wr_addr | output | 4 | Destination register index (registered) |
| wr_data | output | DATA_W | Packed halved result (registered) |
| invalid_op | output | 1 | An undefined selector was seen (registered) |

## Verification
The bench builds the unit with the default DATA_W of 32, which gives 16-bit halfword lanes and 8-bit byte lanes. The 8-bit width lets the byte sweep run every first-operand byte against a dense stride of second-operand bytes in lane 0, with derived bytes in the other lanes. The halfword sweep takes every combination of ten boundary values in all four operand halves and runs it through all four halfword selectors. That sweep includes the most negative, most positive and all-ones cases. Expected lanes come from 32-bit integer arithmetic. Directed cycles cover the condition gate, the undefined selectors and the field positions.

// File: rtl/phalf_pkg.sv
package phalf_pkg;

    typedef enum logic [2:0] {
        OP_H_ADD     = 3'd0,
        OP_H_XSUBADD = 3'd1,
        OP_H_XADDSUB = 3'd2,
        OP_H_SUB     = 3'd3,
        OP_B_ADD     = 3'd4,
        OP_RES5      = 3'd5,
        OP_RES6      = 3'd6,
        OP_B_SUB     = 3'd7
    } hsel_e;

    localparam logic [3:0] COND_ALWAYS = 4'hE;
    localparam int         IDX_W       = 4;

endpackage

// File: rtl/phalf_lane.sv
module phalf_lane #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] y
);
    localparam int EW = W + 1;

    logic [EW-1:0] ea, eb, s;

    always_comb begin
        ea = {a[W-1], a};
        eb = {b[W-1], b};
        s  = sub ? (ea - eb) : (ea + eb);
        y  = s[EW-1:1];
    end

    // R6: halving keeps the sign exact when the operands cannot cancel
    always_comb begin
        if (!sub && (a[W-1] == b[W-1]))
            p_no_overflow_r6: assert (y[W-1] == a[W-1]);
        if (sub && (a[W-1] != b[W-1]))
            p_no_overflow_sub_r6: assert (y[W-1] == a[W-1]);
    end

endmodule

// File: rtl/phalf_datapath.sv
module phalf_datapath
    import phalf_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  hsel_e              op,
    input  logic [DATA_W-1:0]  rn,
    input  logic [DATA_W-1:0]  rm,
    output logic [DATA_W-1:0]  res
);
    localparam int HALF_W  = DATA_W / 2;
    localparam int BYTE_W  = DATA_W / 4;
    localparam int N_HALF  = 2;
    localparam int N_BYTE  = 4;

    logic exch;
    logic [N_HALF-1:0] h_sub;
    logic [DATA_W-1:0] half_res, byte_res;

    always_comb begin
        exch     = (op == OP_H_XSUBADD) || (op == OP_H_XADDSUB);
        h_sub[0] = (op == OP_H_XSUBADD) || (op == OP_H_SUB);
        h_sub[1] = (op == OP_H_XADDSUB) || (op == OP_H_SUB);
    end

    for (genvar i = 0; i < N_HALF; i++) begin : g_half
        localparam int OTHER = N_HALF - 1 - i;
        logic [HALF_W-1:0] b_sel;
        assign b_sel = exch ? rm[OTHER*HALF_W +: HALF_W] : rm[i*HALF_W +: HALF_W];
        phalf_lane #(.W(HALF_W)) u_lane (
            .a   (rn[i*HALF_W +: HALF_W]),
            .b   (b_sel),
            .sub (h_sub[i]),
            .y   (half_res[i*HALF_W +: HALF_W])
        );
    end

    for (genvar j = 0; j < N_BYTE; j++) begin : g_byte
        phalf_lane #(.W(BYTE_W)) u_lane (
            .a   (rn[j*BYTE_W +: BYTE_W]),
            .b   (rm[j*BYTE_W +: BYTE_W]),
            .sub (op == OP_B_SUB),
            .y   (byte_res[j*BYTE_W +: BYTE_W])
        );
    end

    assign res = op[2] ? byte_res : half_res;

endmodule

// File: rtl/phalf_decode.sv
module phalf_decode
    import phalf_pkg::*;
(
    input  logic [31:0]      word,
    input  logic             cond_pass,
    output hsel_e            op,
    output logic [IDX_W-1:0] rn_idx,
    output logic [IDX_W-1:0] rm_idx,
    output logic [IDX_W-1:0] rd_idx,
    output logic             exec_ok,
    output logic             illegal
);
    logic [3:0] cond;
    logic       unused_bits;

    always_comb begin
        cond    = word[31:28];
        op      = hsel_e'(word[7:5]);
        rn_idx  = word[19:16];
        rd_idx  = word[15:12];
        rm_idx  = word[3:0];
        illegal = (op == OP_RES5) || (op == OP_RES6);
        exec_ok = !illegal && ((cond == COND_ALWAYS) || cond_pass);
    end

    assign unused_bits = ^{word[27:20], word[11:8], word[4]};

endmodule

// File: rtl/phalf_unit.sv
module phalf_unit
    import phalf_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_valid,
    input  logic [31:0]       instr_word,
    input  logic              cond_pass,
    input  logic [DATA_W-1:0] rn_data,
    input  logic [DATA_W-1:0] rm_data,
    output logic [3:0]        rn_idx,
    output logic [3:0]        rm_idx,
    output logic              wr_en,
    output logic [3:0]        wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              invalid_op
);
    hsel_e             op;
    logic [IDX_W-1:0]  rd_idx;
    logic              exec_ok, illegal;
    logic [DATA_W-1:0] result;

    phalf_decode u_dec (
        .word      (instr_word),
        .cond_pass (cond_pass),
        .op        (op),
        .rn_idx    (rn_idx),
        .rm_idx    (rm_idx),
        .rd_idx    (rd_idx),
        .exec_ok   (exec_ok),
        .illegal   (illegal)
    );

    phalf_datapath #(.DATA_W(DATA_W)) u_dp (
        .op  (op),
        .rn  (rn_data),
        .rm  (rm_data),
        .res (result)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_en      <= 1'b0;
            invalid_op <= 1'b0;
            wr_addr    <= '0;
            wr_data    <= '0;
        end else begin
            wr_en      <= instr_valid && exec_ok;
            invalid_op <= instr_valid && illegal;
            if (instr_valid && exec_ok) begin
                wr_addr <= rd_idx;
                wr_data <= result;
            end
        end
    end

    // R9: a write and an invalid flag never coincide
    p_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_en, invalid_op}));

    // R10: no request in the cycle after an idle input
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_valid |=> (!wr_en && !invalid_op));

    // R8: a failed condition blocks the write
    p_cond_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && instr_word[31:28] != 4'hE && !cond_pass) |=> !wr_en);

    // R8: the always-code writes for every defined selector
    p_always_exec_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && instr_word[31:28] == 4'hE &&
         instr_word[7:5] != 3'd5 && instr_word[7:5] != 3'd6) |=> wr_en);

endmodule

// File: tb/phalf_unit_tb_top.sv
module phalf_unit_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYC = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [31:0] instr_word = '0;
    logic        cond_pass = 1'b0;
    logic [31:0] rn_data = '0;
    logic [31:0] rm_data = '0;
    logic [3:0]  rn_idx, rm_idx, wr_addr;
    logic        wr_en, invalid_op;
    logic [31:0] wr_data;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    phalf_unit dut_i (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_word(instr_word),
        .cond_pass(cond_pass), .rn_data(rn_data), .rm_data(rm_data),
        .rn_idx(rn_idx), .rm_idx(rm_idx), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .invalid_op(invalid_op)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_word(input logic [3:0] cond, input logic [2:0] sel,
                                            input logic [3:0] rn, input logic [3:0] rd,
                                            input logic [3:0] rm);
        return {cond, 8'h63, rn, rd, 4'hF, sel, 1'b1, rm};
    endfunction

    function automatic logic [15:0] h16(input logic [15:0] a, input logic [15:0] b, input bit sub);
        int sa = int'($signed(a));
        int sb = int'($signed(b));
        int r  = (sub ? sa - sb : sa + sb) >>> 1;
        return r[15:0];
    endfunction

    function automatic logic [7:0] h8(input logic [7:0] a, input logic [7:0] b, input bit sub);
        int sa = int'($signed(a));
        int sb = int'($signed(b));
        int r  = (sub ? sa - sb : sa + sb) >>> 1;
        return r[7:0];
    endfunction

    function automatic logic [31:0] model(input logic [2:0] sel, input logic [31:0] n, input logic [31:0] m);
        logic [31:0] r;
        case (sel)
            3'd0: r = {h16(n[31:16], m[31:16], 0), h16(n[15:0], m[15:0], 0)};
            3'd1: r = {h16(n[31:16], m[15:0], 0), h16(n[15:0], m[31:16], 1)};
            3'd2: r = {h16(n[31:16], m[15:0], 1), h16(n[15:0], m[31:16], 0)};
            3'd3: r = {h16(n[31:16], m[31:16], 1), h16(n[15:0], m[15:0], 1)};
            default: begin
                for (int k = 0; k < 4; k++)
                    r[k*8 +: 8] = h8(n[k*8 +: 8], m[k*8 +: 8], sel == 3'd7);
            end
        endcase
        return r;
    endfunction

    function automatic string sel_tag(input logic [2:0] sel);
        case (sel)
            3'd0: return "R1";
            3'd3: return "R2";
            3'd1: return "R3";
            3'd2: return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic run_op(input bit v, input logic [31:0] w, input logic [31:0] n,
                          input logic [31:0] m, input bit cp);
        @(negedge clk);
        instr_valid = v; instr_word = w; rn_data = n; rm_data = m; cond_pass = cp;
        @(posedge clk);
        #1;
    endtask

    task automatic arith(input logic [2:0] sel, input logic [31:0] n, input logic [31:0] m, input string tag);
        logic [31:0] e;
        e = model(sel, n, m);
        run_op(1, mk_word(4'hE, sel, 4'h2, 4'h5, 4'h7), n, m, 0);
        check(wr_en && wr_data == e, tag, wr_data, e);
    endtask

    logic [15:0] hv [10] = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'h8001,
                             16'hFFFF, 16'h1234, 16'hC000, 16'h4000, 16'hFFFE};

    initial begin
        #(CLK_PERIOD * WATCHDOG_CYC);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog R10 actual=%h expected=%h", 0, 1);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R10: reset state
        check(!wr_en && !invalid_op && wr_data == 0 && wr_addr == 0, "R10 reset", {wr_en, invalid_op, wr_addr}, 0);
        @(negedge clk); rst_n = 1'b1;

        // R6: extreme operands
        arith(3'd0, 32'h8000_8000, 32'h8000_8000, "R6 min+min");
        check(wr_data == 32'h8000_8000, "R6 min+min value", wr_data, 32'h8000_8000);
        arith(3'd3, 32'h7FFF_7FFF, 32'h8000_8000, "R6 max-min");
        check(wr_data == 32'h7FFF_7FFF, "R6 max-min value", wr_data, 32'h7FFF_7FFF);
        arith(3'd4, 32'h8080_8080, 32'h8080_8080, "R6 byte min+min");
        check(wr_data == 32'h8080_8080, "R6 byte value", wr_data, 32'h8080_8080);
        arith(3'd0, 32'h0000_0002, 32'h0000_0004, "R6 lane0 placement");
        check(wr_data == 32'h0000_0003, "R6 lane0 lsb", wr_data, 32'h0000_0003);

        // R7: field positions
        @(negedge clk);
        instr_valid = 1; instr_word = mk_word(4'hE, 3'd0, 4'hA, 4'hC, 4'h3);
        #1;
        check(rn_idx == 4'hA && rm_idx == 4'h3, "R7 src idx", {rn_idx, rm_idx}, 32'hA3);
        @(posedge clk); #1;
        check(wr_addr == 4'hC, "R7 dest idx", wr_addr, 4'hC);

        // R8: condition gate
        run_op(1, mk_word(4'h0, 3'd0, 1, 9, 2), 32'h10, 32'h20, 0);
        check(!wr_en && wr_addr == 4'hC, "R8 fail no write", {wr_en, wr_addr}, 32'h0C);
        run_op(1, mk_word(4'h0, 3'd0, 1, 9, 2), 32'h10, 32'h20, 1);
        check(wr_en && wr_addr == 4'h9 && wr_data == 32'h18, "R8 pass write", wr_data, 32'h18);
        run_op(1, mk_word(4'hE, 3'd3, 1, 4, 2), 32'h10, 32'h20, 0);
        check(wr_en && wr_addr == 4'h4, "R8 always", {wr_en, wr_addr}, 32'h14);

        // R9: undefined selectors
        run_op(1, mk_word(4'hE, 3'd5, 1, 6, 2), 32'h10, 32'h20, 1);
        check(invalid_op && !wr_en && wr_addr == 4'h4, "R9 sel5", {invalid_op, wr_en, wr_addr}, 32'h24);
        run_op(1, mk_word(4'h3, 3'd6, 1, 6, 2), 32'h10, 32'h20, 0);
        check(invalid_op && !wr_en, "R9 sel6", {invalid_op, wr_en}, 32'h2);

        // R10: idle cycle
        run_op(0, mk_word(4'hE, 3'd0, 1, 7, 2), 32'h10, 32'h20, 1);
        check(!wr_en && !invalid_op, "R10 idle", {wr_en, invalid_op}, 0);

        // R1-R4 sweep over halfword boundary values
        for (int s = 0; s < 4; s++)
            for (int i = 0; i < 10; i++)
                for (int j = 0; j < 10; j++)
                    for (int k = 0; k < 10; k++)
                        for (int l = 0; l < 10; l++)
                            arith(3'(s), {hv[i], hv[j]}, {hv[k], hv[l]}, sel_tag(3'(s)));

        // R5 byte sweep: lane 0 dense, other lanes derived
        for (int a = 0; a < 256; a++)
            for (int b = 0; b < 256; b += 3) begin
                logic [7:0] ab, bb;
                ab = 8'(a); bb = 8'(b);
                arith(3'd4, {ab + 8'd3, ab ^ 8'hA5, ~ab, ab}, {bb, ~bb, bb + 8'd7, bb ^ 8'h3C}, "R5 add");
                arith(3'd7, {ab + 8'd3, ab ^ 8'hA5, ~ab, ab}, {bb, ~bb, bb + 8'd7, bb ^ 8'h3C}, "R5 sub");
            end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule